// File: doc/BRIEF.md
# Bus Cycle Wait-State Sequencer

This block steps a processor bus cycle through four timing states for one chip-select region. The first state, T1, opens the address phase. T2 and T3 carry the data phase. Read data is taken at the start of T4, which closes the cycle. A slow memory or peripheral gets more time through extra copies of T3, called wait states, placed before T4.

Two sources set how many wait states a cycle gets. The first is a programmed wait count, 0 to 15, which is latched when the request is accepted. The second is an external READY line that arrives asynchronously and runs through a two-flop synchroniser. An enable bit decides whether READY is honoured at all. When it is honoured, the programmed count is only a minimum: T4 starts only once the count has run out and READY reads as ready. READY runs in one of two schemes. In the normally-ready scheme the slave holds the line high and pulls it low to ask for waits. In the normally-not-ready scheme the slave pulses the line high to end the waits, and that pulse is remembered.

The bus master drives a request and the region settings. It reads back the current state, an address strobe, a data strobe and a one-clock done pulse, and it uses the done pulse to capture read data.

Top module: `bus_wait_seq`

## Requirements
- R1: While `rst` is high, and on the first clock after it is released, `t_state` is 0 (idle) and `addr_stb`, `data_stb` and `cyc_done` are low.
- R2: The state codes on `t_state` are 0 idle, 1 T1, 2 T2, 3 T3 and 4 T4. A request seen in idle moves the block to T1 on the next clock. T1 is always followed by T2, and T2 by T3.
- R3: With a wait count of 0 and `rdy_en` low, a cycle lasts exactly four clocks (T1, T2, T3, T4), and T3 lasts one clock.
- R4: With `rdy_en` low and a wait count of N (0 to 15), T3 lasts N+1 clocks, so the cycle lasts N+4 clocks.
- R5: `addr_stb` is high exactly while the block is in T1. `data_stb` is high exactly while it is in T2, T3 or T4.
- R6: `cyc_done` is high exactly while the block is in T4, and T4 lasts one clock.
- R7: A request is accepted only in idle or in T4. A request raised only during T1 to T3 is ignored, so the block returns to idle after T4. A request held in T4 starts T1 on the next clock.
- R8: With `rdy_en` low, the level of `rdy_line` has no effect on cycle length.
- R9: With `rdy_en` high and `rdy_mode` = 1 (normally ready), T4 follows the first T3 clock in which the count has run out and the synchronised line is high. If the line rises during the j-th T3 clock, T3 lasts max(N+1, j+2) clocks. A high pulse that has ended before T3 is forgotten.
- R10: With `rdy_en` high and `rdy_mode` = 0 (normally not ready), a high level seen on the synchronised line during T2 or T3 is remembered for the rest of the cycle. A short pulse therefore ends the waits as soon as the count runs out.
- R11: The wait count, `rdy_en` and `rdy_mode` are latched when a request is accepted. Changing them later in the cycle does not change that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_req | input | 1 | Bus cycle request |
| wait_cnt | input | 4 | Programmed wait states for the region |
| rdy_en | input | 1 | 1 = honour the external READY line |
| rdy_mode | input | 1 | 1 = normally ready, 0 = normally not ready |
| rdy_line | input | 1 | Asynchronous external READY line |
| t_state | output | 3 | Current state: 0 idle, 1 T1, 2 T2, 3 T3, 4 T4 |
| addr_stb | output | 1 | Address-phase strobe |
| data_stb | output | 1 | Data-phase strobe |
| cyc_done | output | 1 | One-clock end-of-cycle pulse in T4 |

## Verification
The assertions check the parts of the state sequence that hold on every cycle. These are the fixed T1 to T2 to T3 steps, T3 holding while wait states remain, no request being taken in mid-cycle, and one-clock T4 and done pulses. They also check that the strobes match the state, that the down-counter never wraps, and that T4 follows at once when READY is ignored and the count is spent. Only the bench scenarios can show the actual cycle lengths for each wait count. The same holds for the two-clock delay through the synchroniser, the difference between a remembered pulse and a forgotten one in the two READY schemes, and the fact that settings are fixed at acceptance.

// File: rtl/bws_pkg.sv
package bws_pkg;

  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_T3   = 3'd3,
    TS_T4   = 3'd4
  } tstate_e;

  localparam int TSTATE_W = 3;

endpackage

// File: rtl/bws_rdy_sync.sv
module bws_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= async_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[LAST-1:0], async_in};
      end
    end
  endgenerate

  assign sync_out = chain[LAST];

endmodule

// File: rtl/bws_wait_cnt.sv
module bws_wait_cnt #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WAIT_W-1:0] load_val,
  input  logic              dec_en,
  output logic              expired
);

  localparam logic [WAIT_W-1:0] ZERO = '0;
  localparam logic [WAIT_W-1:0] ONE  = {{(WAIT_W-1){1'b0}}, 1'b1};

  logic [WAIT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= ZERO;
    end else if (load) begin
      remain <= load_val;
    end else if (dec_en && (remain != ZERO)) begin
      remain <= remain - ONE;
    end
  end

  assign expired = (remain == ZERO);

  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (dec_en && !load && remain == ZERO) |=> (remain == ZERO)); // R4

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (dec_en && !load && remain != ZERO) |=> (remain == $past(remain) - ONE)); // R4

  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> (remain == $past(load_val))); // R11

endmodule

// File: rtl/bws_ready_qual.sv
module bws_ready_qual (
  input  logic clk,
  input  logic rst,
  input  logic capture,
  input  logic en_in,
  input  logic mode_in,
  input  logic sync_rdy,
  input  logic watch,
  output logic rdy_used,
  output logic rdy_ok
);

  logic en_q;
  logic mode_q;
  logic seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      mode_q <= 1'b1;
      seen_q <= 1'b0;
    end else if (capture) begin
      en_q   <= en_in;
      mode_q <= mode_in;
      seen_q <= 1'b0;
    end else if (watch && sync_rdy) begin
      seen_q <= 1'b1;
    end
  end

  always_comb begin
    if (!en_q)       rdy_ok = 1'b1;
    else if (mode_q) rdy_ok = sync_rdy;
    else             rdy_ok = seen_q | sync_rdy;
  end

  assign rdy_used = en_q;

  AST_SEEN_STICKY: assert property (@(posedge clk) disable iff (rst)
    (seen_q && !capture) |=> seen_q); // R10

  AST_SEEN_CLEARED: assert property (@(posedge clk) disable iff (rst)
    capture |=> !seen_q); // R11

endmodule

// File: rtl/bws_fsm.sv
module bws_fsm
  import bws_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    req,
  input  logic    cnt_expired,
  input  logic    rdy_ok,
  output tstate_e state,
  output logic    accept,
  output logic    in_t3,
  output logic    watch,
  output logic    addr_stb,
  output logic    data_stb,
  output logic    done
);

  tstate_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      TS_IDLE: if (req) nxt = TS_T1;
      TS_T1:   nxt = TS_T2;
      TS_T2:   nxt = TS_T3;
      TS_T3:   if (cnt_expired && rdy_ok) nxt = TS_T4;
      TS_T4:   nxt = req ? TS_T1 : TS_IDLE;
      default: nxt = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= TS_IDLE;
      addr_stb <= 1'b0;
      data_stb <= 1'b0;
      done     <= 1'b0;
    end else begin
      state    <= nxt;
      addr_stb <= (nxt == TS_T1);
      data_stb <= (nxt == TS_T2) || (nxt == TS_T3) || (nxt == TS_T4);
      done     <= (nxt == TS_T4);
    end
  end

  assign accept = req && ((state == TS_IDLE) || (state == TS_T4));
  assign in_t3  = (state == TS_T3);
  assign watch  = (state == TS_T2) || (state == TS_T3);

  AST_IDLE_TO_T1: assert property (@(posedge clk) disable iff (rst)
    (state == TS_IDLE && req) |=> (state == TS_T1)); // R2

  AST_T1_TO_T2: assert property (@(posedge clk) disable iff (rst)
    (state == TS_T1) |=> (state == TS_T2)); // R2

  AST_T2_TO_T3: assert property (@(posedge clk) disable iff (rst)
    (state == TS_T2) |=> (state == TS_T3)); // R2

  AST_T3_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (state == TS_T3 && !cnt_expired) |=> (state == TS_T3)); // R4

  AST_T4_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
    (state == TS_T4) |=> (state != TS_T4)); // R6

  AST_NO_MIDCYCLE_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (state == TS_T1 || state == TS_T2) |=> (state != TS_T1)); // R7

  AST_ADDR_IN_T1: assert property (@(posedge clk) disable iff (rst)
    addr_stb |-> (state == TS_T1)); // R5

  AST_DONE_IN_T4: assert property (@(posedge clk) disable iff (rst)
    done |-> (state == TS_T4)); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |=> $fell(done)); // R6

endmodule

// File: rtl/bus_wait_seq.sv
module bus_wait_seq
  import bws_pkg::*;
#(
  parameter int WAIT_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_req,
  input  logic [WAIT_W-1:0] wait_cnt,
  input  logic              rdy_en,
  input  logic              rdy_mode,
  input  logic              rdy_line,
  output logic [TSTATE_W-1:0] t_state,
  output logic              addr_stb,
  output logic              data_stb,
  output logic              cyc_done
);

  tstate_e state;
  logic    accept;
  logic    in_t3;
  logic    watch;
  logic    cnt_expired;
  logic    rdy_sync;
  logic    rdy_ok;
  logic    rdy_used;

  bws_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (rdy_line),
    .sync_out (rdy_sync)
  );

  bws_wait_cnt #(.WAIT_W(WAIT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_val (wait_cnt),
    .dec_en   (in_t3),
    .expired  (cnt_expired)
  );

  bws_ready_qual u_qual (
    .clk      (clk),
    .rst      (rst),
    .capture  (accept),
    .en_in    (rdy_en),
    .mode_in  (rdy_mode),
    .sync_rdy (rdy_sync),
    .watch    (watch),
    .rdy_used (rdy_used),
    .rdy_ok   (rdy_ok)
  );

  bws_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .req         (cyc_req),
    .cnt_expired (cnt_expired),
    .rdy_ok      (rdy_ok),
    .state       (state),
    .accept      (accept),
    .in_t3       (in_t3),
    .watch       (watch),
    .addr_stb    (addr_stb),
    .data_stb    (data_stb),
    .done        (cyc_done)
  );

  assign t_state = state;

  AST_NO_EXT_WAIT: assert property (@(posedge clk) disable iff (rst)
    (state == TS_T3 && cnt_expired && !rdy_used) |=> (state == TS_T4)); // R8

  AST_WAIT_FOR_READY: assert property (@(posedge clk) disable iff (rst)
    (state == TS_T3 && !rdy_ok) |=> (state == TS_T3)); // R9

  AST_DATA_PHASE: assert property (@(posedge clk) disable iff (rst)
    data_stb |-> (state == TS_T2 || state == TS_T3 || state == TS_T4)); // R5

endmodule

// File: tb/test_bus_wait_seq.sv
module test_bus_wait_seq;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cyc_req = 1'b0;
  logic [3:0] wait_cnt = '0;
  logic       rdy_en = 1'b0;
  logic       rdy_mode = 1'b1;
  logic       rdy_line = 1'b0;
  logic [2:0] t_state;
  logic       addr_stb;
  logic       data_stb;
  logic       cyc_done;

  int n_chk  = 0;
  int n_fail = 0;
  int n_clk  = 0;
  bit ended  = 1'b0;

  always #2.5 clk = ~clk;

  bus_wait_seq i_bus_wait_seq (
    .clk      (clk),
    .rst      (rst),
    .cyc_req  (cyc_req),
    .wait_cnt (wait_cnt),
    .rdy_en   (rdy_en),
    .rdy_mode (rdy_mode),
    .rdy_line (rdy_line),
    .t_state  (t_state),
    .addr_stb (addr_stb),
    .data_stb (data_stb),
    .cyc_done (cyc_done)
  );

  // vector fields: [11:8] wait, [7] rdy_en, [6] rdy_mode, [5] line level, [4:0] expected T3 clocks
  localparam int NV = 8;
  localparam logic [11:0] VEC [NV] = '{
    {4'd0,  1'b0, 1'b1, 1'b0, 5'd1},   // R3 base cycle
    {4'd3,  1'b0, 1'b0, 1'b0, 5'd4},   // R4, R8 line low ignored
    {4'd15, 1'b0, 1'b1, 1'b0, 5'd16},  // R4 max count
    {4'd7,  1'b0, 1'b0, 1'b1, 5'd8},   // R4, R8 line high ignored
    {4'd0,  1'b1, 1'b1, 1'b1, 5'd1},   // R9 ready already high
    {4'd5,  1'b1, 1'b1, 1'b1, 5'd6},   // R9 count is the minimum
    {4'd2,  1'b1, 1'b0, 1'b1, 5'd3},   // R10 level held
    {4'd1,  1'b0, 1'b1, 1'b1, 5'd2}    // R4
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    n_clk++;
    if (n_clk > 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", n_clk, 100000);
      finish_run();
    end
  end

  task automatic settle_line(input logic lvl);
    rdy_line = lvl;
    repeat (4) @(negedge clk);
  endtask

  // One bus cycle. raise_j: raise the line in that T3 clock (0 = never).
  // pulse_t1: high pulse on the line from T1 into T2. mess_t2: change settings in T2.
  // req_t2: request pulse during T2 only.
  task automatic run_cycle(input logic [3:0] w, input logic en, input logic md,
                           input int raise_j, input bit pulse_t1, input bit mess_t2,
                           input bit req_t2, input int exp_t3, input string tag);
    int  t3 = 0;
    int  guard = 0;
    bit  stb_ok = 1'b1;
    @(negedge clk);
    wait_cnt = w; rdy_en = en; rdy_mode = md; cyc_req = 1'b1;
    @(negedge clk);
    cyc_req = 1'b0;
    check(t_state == 3'd1, "R2 accept into T1", t_state, 1);
    forever begin
      if (addr_stb != (t_state == 3'd1)) stb_ok = 1'b0;
      if (data_stb != (t_state >= 3'd2 && t_state <= 3'd4)) stb_ok = 1'b0;
      if (cyc_done != (t_state == 3'd4)) stb_ok = 1'b0;
      if (t_state == 3'd1 && pulse_t1) rdy_line = 1'b1;
      if (t_state == 3'd2) begin
        if (pulse_t1) rdy_line = 1'b0;
        if (mess_t2) begin
          wait_cnt = 4'd15; rdy_en = 1'b1; rdy_mode = 1'b1; rdy_line = 1'b0;
        end
        if (req_t2) cyc_req = 1'b1;
      end
      if (t_state == 3'd3) begin
        cyc_req = 1'b0;
        t3++;
        if (t3 == raise_j) rdy_line = 1'b1;
      end
      if (t_state == 3'd4) break;
      guard++;
      if (guard > 60) break;
      @(negedge clk);
    end
    check(t3 == exp_t3, tag, t3, exp_t3);
    check(stb_ok, "R5/R6 strobes and done track state", stb_ok, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(t_state == 3'd0 && !addr_stb && !data_stb && !cyc_done,
          "R1 state during reset", t_state, 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(t_state == 3'd0 && !addr_stb && !data_stb && !cyc_done,
          "R1 idle after reset", t_state, 0);

    for (int i = 0; i < NV; i++) begin
      logic [11:0] v = VEC[i];
      string tag;
      if (v[7]) tag = v[6] ? "R9 vector T3 length" : "R10 vector T3 length";
      else      tag = (v[11:8] == 0) ? "R3 vector T3 length" : "R4/R8 vector T3 length";
      rdy_line = v[5];
      run_cycle(v[11:8], v[7], v[6], 0, 1'b0, 1'b0, 1'b0, int'(v[4:0]), tag);
    end

    // R9: line rises in the 5th T3 clock, two-flop latency -> 7 T3 clocks
    settle_line(1'b0);
    run_cycle(4'd0, 1'b1, 1'b1, 5, 1'b0, 1'b0, 1'b0, 7, "R9 sync latency");
    // R9: count dominates when the line is early enough
    settle_line(1'b0);
    run_cycle(4'd9, 1'b1, 1'b1, 2, 1'b0, 1'b0, 1'b0, 10, "R9 count minimum");
    // R10: short pulse remembered, ends at count expiry
    settle_line(1'b0);
    run_cycle(4'd3, 1'b1, 1'b0, 0, 1'b1, 1'b0, 1'b0, 4, "R10 pulse remembered");
    // R9: same pulse forgotten, only the later level in T3 clock 6 ends it
    settle_line(1'b0);
    run_cycle(4'd3, 1'b1, 1'b1, 6, 1'b1, 1'b0, 1'b0, 8, "R9 pulse forgotten");
    // R11: settings changed in T2 do not change this cycle
    settle_line(1'b1);
    run_cycle(4'd2, 1'b0, 1'b1, 0, 1'b0, 1'b1, 1'b0, 3, "R11 settings latched");
    // R7: request raised only in T2/T3 is ignored
    settle_line(1'b1);
    run_cycle(4'd1, 1'b0, 1'b1, 0, 1'b0, 1'b0, 1'b1, 2, "R7 cycle with mid request");
    @(negedge clk);
    check(t_state == 3'd0, "R7 mid-cycle request ignored", t_state, 0);

    // R7: request held in T4 starts T1 next clock; R3 four-clock cycle
    @(negedge clk);
    wait_cnt = 4'd0; rdy_en = 1'b0; cyc_req = 1'b1;
    @(negedge clk);
    check(t_state == 3'd1, "R2 first T1", t_state, 1);
    repeat (3) @(negedge clk);
    check(t_state == 3'd4 && cyc_done, "R3 T4 on fourth clock", t_state, 4);
    @(negedge clk);
    check(t_state == 3'd1, "R7 back-to-back T1 after T4", t_state, 1);
    check(!cyc_done, "R6 done low after T4", cyc_done, 0);
    cyc_req = 1'b0;
    repeat (3) @(negedge clk);
    check(t_state == 3'd4, "R3 second cycle T4", t_state, 4);
    @(negedge clk);
    check(t_state == 3'd0, "R7 idle when request dropped", t_state, 0);

    // R1: reset in mid-cycle
    wait_cnt = 4'd8; cyc_req = 1'b1;
    @(negedge clk);
    cyc_req = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(t_state == 3'd0 && !data_stb && !cyc_done, "R1 reset in mid-cycle", t_state, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    finish_run();
  end

endmodule